// File: doc/BRIEF.md
# Monitor Channel Round-Robin Sequencer

This block decides which of ten monitor inputs a single shared converter digitizes next. It drives a channel select with a one-cycle start strobe, then waits for the converter to report completion. When completion arrives it returns the converted word, labelled with the index of the channel it belongs to. Only one conversion is ever in flight.

The channels are temperature, supply voltage, four primary monitors and four auxiliary monitors. A mode input chooses between two frame shapes. The short frame has six slots and carries only the core channels. The long frame has eight slots: the core six, followed by one pair of auxiliary channels. The two auxiliary pairs take turns from one long frame to the next, so every core channel is still sampled in every frame. The mode input is read only at frame boundaries. A pulse marks the final result of each frame.

Top module: `mon_seq_sched`

## Requirements
- R1: A synchronous active-high `rst` clears `conv_start`, `res_valid` and `frame_done` and sets `conv_sel` to 0. The cycle after release is idle. The first conversion after release is channel 0, and the auxiliary pair selector starts at the first pair (channels 6 and 7).
- R2: Channel indices are 0 for temperature, 1 for supply, and 2 to 9 for monitors 1 to 8. When the latched mode is 0, the conversion order is 0,1,2,3,4,5, repeating.
- R3: When the latched mode is 1, each frame is 0,1,2,3,4,5 followed by one auxiliary pair. Consecutive long frames alternate between the pair 6,7 and the pair 8,9, beginning with 6,7.
- R4: `conv_start` is high for exactly one cycle per conversion. No new start is issued until `conv_done` has been seen for the previous one. `conv_sel` holds steady from the start until completion.
- R5: The cycle after the sequencer samples `conv_done` high while waiting, `res_valid` pulses for one cycle. In that cycle `res_chan` equals the channel that was selected and `res_data` equals `conv_data` as sampled with `conv_done`.
- R6: `frame_done` is high only together with the `res_valid` of a frame's final slot: channel 5 in a short frame, channel 7 or 9 in a long frame.
- R7: `aux_en` is sampled only at reset and at the completion of a frame's final slot. Changes at any other time have no effect on the frame in progress. Entering long-frame mode always restarts the pair selector at the 6,7 pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| aux_en | input | 1 | Frame mode request: 0 short, 1 long |
| conv_start | output | 1 | One-cycle conversion start strobe |
| conv_sel | output | CH_W | Channel being converted |
| conv_done | input | 1 | Converter completion pulse |
| conv_data | input | DATA_W | Converter result, valid with conv_done |
| res_valid | output | 1 | Tagged result strobe |
| res_chan | output | CH_W | Channel index of the result |
| res_data | output | DATA_W | Result word |
| frame_done | output | 1 | Marks the final result of a frame |

## Verification
The bench toggles the mode input at random points inside frames. A design that latched the mode mid-frame would then emit a frame of the wrong length, or an auxiliary pair after only some of the core slots. Long runs in long-frame mode expose a pair selector that fails to alternate, or one that resumes at the 8,9 pair after a short-mode interval instead of restarting at 6,7. A reset in the middle of a frame must return the order to temperature. Converter latencies vary from one to four cycles, which exposes a result tag or data word taken from the wrong cycle and a start strobe issued before the previous conversion has finished.

// File: rtl/mon_seq_sched.sv
module mon_seq_sched #(
  parameter int DATA_W = 16,
  parameter int CH_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              aux_en,
  output logic              conv_start,
  output logic [CH_W-1:0]   conv_sel,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic              res_valid,
  output logic [CH_W-1:0]   res_chan,
  output logic [DATA_W-1:0] res_data,
  output logic              frame_done
);
  localparam int CORE_SLOTS = 6;
  localparam int EXT_SLOTS  = 8;
  localparam int SLOT_W     = $clog2(EXT_SLOTS);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} st_t;

  st_t             st;
  logic [SLOT_W-1:0] slot;
  logic            ext_q;
  logic            pair_q;

  wire last = (slot == SLOT_W'(ext_q ? EXT_SLOTS - 1 : CORE_SLOTS - 1));
  wire take = (st == S_WAIT) && conv_done;

  assign conv_start = (st == S_ISSUE);
  assign conv_sel   = (int'(slot) < CORE_SLOTS) ? CH_W'(slot)
                    : CH_W'(slot) + CH_W'({pair_q, 1'b0});

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      slot       <= '0;
      ext_q      <= aux_en;
      pair_q     <= 1'b0;
      res_valid  <= 1'b0;
      frame_done <= 1'b0;
      res_chan   <= '0;
      res_data   <= '0;
    end else begin
      res_valid  <= take;
      frame_done <= take && last;
      case (st)
        S_IDLE:  st <= S_ISSUE;
        S_ISSUE: st <= S_WAIT;
        default: if (conv_done) st <= S_ISSUE;
      endcase
      if (take) begin
        res_chan <= conv_sel;
        res_data <= conv_data;
        if (last) begin
          slot   <= '0;
          ext_q  <= aux_en;
          pair_q <= aux_en && ext_q && !pair_q;
        end else begin
          slot <= slot + SLOT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/mon_seq_sched_chk.sv
module mon_seq_sched_chk #(
  parameter int CH_W = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            conv_start,
  input logic [CH_W-1:0] conv_sel,
  input logic            conv_done,
  input logic            res_valid,
  input logic [CH_W-1:0] res_chan,
  input logic            frame_done
);
  assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!conv_start && conv_sel == '0));

  assert_chan_range_R2: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_chan <= CH_W'(9)));

  assert_start_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);

  assert_sel_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!conv_start && !$past(rst)) |-> $stable(conv_sel));

  assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  assert_valid_cause_R5: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(conv_done));

  assert_frame_end_R6: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (res_valid && (res_chan == CH_W'(5) || res_chan == CH_W'(7)
                                  || res_chan == CH_W'(9))));
endmodule

bind mon_seq_sched mon_seq_sched_chk #(.CH_W(CH_W)) u_chk (
  .clk(clk), .rst(rst), .conv_start(conv_start), .conv_sel(conv_sel),
  .conv_done(conv_done), .res_valid(res_valid), .res_chan(res_chan),
  .frame_done(frame_done)
);

// File: tb/tb_mon_seq_sched.sv
module tb_mon_seq_sched;
  localparam int DW = 16;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          aux_en = 1'b0;
  logic          conv_start;
  logic [CW-1:0] conv_sel;
  logic          conv_done = 1'b0;
  logic [DW-1:0] conv_data = '0;
  logic          res_valid;
  logic [CW-1:0] res_chan;
  logic [DW-1:0] res_data;
  logic          frame_done;

  mon_seq_sched #(.DATA_W(DW), .CH_W(CW)) dut (
    .clk(clk), .rst(rst), .aux_en(aux_en), .conv_start(conv_start),
    .conv_sel(conv_sel), .conv_done(conv_done), .conv_data(conv_data),
    .res_valid(res_valid), .res_chan(res_chan), .res_data(res_data),
    .frame_done(frame_done)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int unsigned toggle_pct = 0;

  // bench-side model of the expected order
  int       m_slot = 0;
  bit       m_ext = 0, m_pair = 0;
  bit       busy = 0, pend = 0, aux_snap = 0, first_after_rst = 0;
  int       cnt = 0, rst_cycles = 0, stall = 0;
  logic [CW-1:0] rec_sel;
  logic [DW-1:0] rec_data;

  function automatic int exp_chan(int s, bit p);
    if (s < 6) return s;
    return p ? s + 2 : s;
  endfunction

  function automatic int frame_len(bit e);
    return e ? 8 : 6;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(negedge clk) begin
    if (rst) begin
      rst_cycles++;
      if (rst_cycles >= 2) begin
        check(!conv_start && !res_valid && !frame_done, "R1 idle outputs in reset",
              int'({conv_start, res_valid, frame_done}), 0);
        check(conv_sel == '0, "R1 select in reset", int'(conv_sel), 0);
      end
      m_slot = 0; m_ext = aux_en; m_pair = 0;
      busy = 0; pend = 0; conv_done = 1'b0; stall = 0;
      first_after_rst = 1;
    end else begin
      rst_cycles = 0;
      if (toggle_pct != 0 && ($urandom % 100) < toggle_pct) aux_en = ~aux_en;
      if (res_valid) begin
        int ec;
        bit lst;
        ec  = exp_chan(m_slot, m_pair);
        lst = (m_slot == frame_len(m_ext) - 1);
        check(pend, "R5 result without completion", 1, int'(pend));
        check(res_chan == CW'(ec), (m_slot < 6) ? "R2 channel order" : "R3 aux pair order",
              int'(res_chan), ec);
        check(res_data == rec_data, "R5 result data", int'(res_data), int'(rec_data));
        check(frame_done == lst, "R6 frame end", int'(frame_done), int'(lst));
        pend = 0; stall = 0;
        if (lst) begin
          m_pair = aux_snap && m_ext && !m_pair;
          m_ext  = aux_snap;
          m_slot = 0;
        end else m_slot++;
      end else begin
        check(!frame_done, "R6 stray frame end", int'(frame_done), 0);
        stall++;
        if (stall > 50) begin
          check(0, "R4 converter stalled", stall, 0);
          finish_run();
        end
      end
      conv_done = 1'b0;
      if (conv_start) begin
        int ec;
        ec = exp_chan(m_slot, m_pair);
        check(!busy, "R4 start while busy", 1, 0);
        if (first_after_rst) check(conv_sel == '0, "R1 first channel", int'(conv_sel), 0);
        else check(conv_sel == CW'(ec), "R7 select follows latched mode", int'(conv_sel), ec);
        first_after_rst = 0;
        busy = 1; rec_sel = conv_sel; cnt = 1 + int'($urandom % 4);
      end else if (busy) begin
        check(conv_sel == rec_sel, "R4 select held", int'(conv_sel), int'(rec_sel));
        cnt--;
        if (cnt == 0) begin
          aux_snap  = aux_en;
          rec_data  = DW'($urandom);
          conv_data = rec_data;
          conv_done = 1'b1;
          busy = 0; pend = 1;
        end
      end
    end
  end

  task automatic wait_cycles(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    void'($urandom(32'd1234));
    #2;
    wait_cycles(3);
    rst = 1'b0;
    wait_cycles(300);        // short frames only
    aux_en = 1'b1;
    wait_cycles(600);        // long frames, pair alternation
    toggle_pct = 3;          // mode flips mid-frame
    wait_cycles(20000);
    toggle_pct = 0;
    aux_en = 1'b1;
    wait_cycles(37);         // reset lands mid-frame
    rst = 1'b1;
    wait_cycles(3);
    rst = 1'b0;
    wait_cycles(400);
    aux_en = 1'b0;
    wait_cycles(200);
    aux_en = 1'b1;           // re-entry must restart at the first pair
    wait_cycles(400);
    finish_run();
  end

  initial begin
    #1_500_000;
    check(0, "R4 watchdog expired", 0, 1);
    finish_run();
  end
endmodule